// File: doc/BRIEF.md
# Multi-Mode Feedback Shift Register

The block is a shift register, four stages wide by default, that advances by one position on every enabled rising clock edge. Each stage takes the value of the stage before it. The first stage is fed by a two-way selector. In load mode it takes an external serial bit, which is how a pattern is seeded. In run mode it takes a feedback bit that the register computes from its own contents.

Three kinds of feedback are available:
- **Ring:** a plain copy of the last stage.
- **Twisted ring:** the complement of the last stage.
- **Linear feedback:** the XOR of a selectable group of taps, which can be the maximal-length set or a shorter alternative pair.

The block is used as a cheap counter or pattern sequencer. The whole state is visible on a parallel output.

Every edge is classified by a small source selector into one of five named sources. The transitions between them depend only on the control inputs in the same cycle:
- **SRC_HOLD:** the shift enable is low.
- **SRC_SERIAL:** enable high, load mode.
- **SRC_RING:** enable high, run mode, feedback code 00.
- **SRC_TWIST:** enable high, run mode, feedback code 01.
- **SRC_LFSR:** enable high, run mode, feedback code 1x.

Any source can follow any other on the next edge. A synchronous reset overrides all of them.

Top module: `fbsr_top`

## Requirements
- R1: A high `rst` at a rising edge clears every stage to zero, whatever the other inputs are.
- R2: On an enabled edge, bit k of `q` (stage k+1) takes the previous bit k-1 for k ≥ 1, and `q[0]` takes the selected input bit.
- R3: With `sel_run` = 0 (load mode), `q[0]` takes `ser_in`, and `fb_mode` and `tap_sel` have no effect.
- R4: With `shift_en` = 0 and `rst` = 0, `q` keeps its value, whatever `ser_in`, `sel_run`, `fb_mode` and `tap_sel` are.
- R5: `fb_mode` = 00 in run mode feeds back `q[WIDTH-1]`, so a loaded pattern returns after WIDTH edges. For width 4, the pattern 1100 has period 4.
- R6: `fb_mode` = 01 in run mode feeds back the complement of `q[WIDTH-1]`. Starting from all zeros, width 4 returns to all zeros after 8 edges.
- R7: `fb_mode` = 10 or 11 in run mode, with `tap_sel` = 0, feeds back the XOR of the maximal taps. For width 4 these are `q[3]^q[2]`, and any nonzero state recurs after exactly 15 edges.
- R8: In linear-feedback mode the all-zero state maps to itself.
- R9: With `tap_sel` = 1 in linear-feedback mode, the feedback is `q[WIDTH-1]^q[WIDTH-3]`. For width 4 this is `q[3]^q[1]`, and state 0001 recurs after 6 edges.
- R10: The width parameter selects the maximal taps used in R7:
  - width 8 uses `q[7]^q[6]^q[5]^q[0]`, giving period 255 from a nonzero state;
  - width 32 uses `q[31]^q[30]^q[29]^q[9]`;
  - other widths use `q[WIDTH-1]^q[WIDTH-2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance the register when high, hold when low |
| ser_in | input | 1 | Serial data for load mode |
| sel_run | input | 1 | 0 = load from `ser_in`, 1 = feedback |
| fb_mode | input | 2 | 00 ring, 01 twisted ring, 1x linear feedback |
| tap_sel | input | 1 | 0 = maximal taps, 1 = alternative pair |
| q | output | WIDTH | Parallel state, `q[0]` is the first stage |

## Verification
Seeds are shifted in serially: the pattern 1100 for the ring, all zeros for the twisted ring, all ones for the maximal-tap linear feedback, and a single one for the alternative taps. From each seed the bench counts edges until the seed recurs. Periods of 4, 8, 15 and 6 tell the four feedback functions apart, because each wrong tap or missing inversion gives a different count. The all-zero seed in linear-feedback mode separates the lock-up case from the others. Each step is also compared against a scoreboard, including edges with the enable low and load edges with a nonzero feedback code. An 8-bit instance is run to its full 255-state period to check the width-dependent taps.

// File: rtl/fbsr_pkg.sv
package fbsr_pkg;

    typedef enum logic [1:0] {
        FB_RING     = 2'b00,
        FB_TWIST    = 2'b01,
        FB_LFSR     = 2'b10,
        FB_LFSR_ALT = 2'b11
    } fb_mode_e;

    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_SERIAL = 3'd1,
        SRC_RING   = 3'd2,
        SRC_TWIST  = 3'd3,
        SRC_LFSR   = 3'd4
    } src_e;

endpackage

// File: rtl/fbsr_src_sel.sv
module fbsr_src_sel
    import fbsr_pkg::*;
(
    input  logic     shift_en,
    input  logic     sel_run,
    input  fb_mode_e mode,
    output src_e     src
);

    always_comb begin
        if (!shift_en) begin
            src = SRC_HOLD;
        end else if (!sel_run) begin
            src = SRC_SERIAL;
        end else begin
            unique case (mode)
                FB_RING:              src = SRC_RING;
                FB_TWIST:             src = SRC_TWIST;
                FB_LFSR, FB_LFSR_ALT: src = SRC_LFSR;
                default:              src = SRC_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/fbsr_feedback.sv
module fbsr_feedback
    import fbsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] state,
    input  src_e             src,
    input  logic             ser_in,
    input  logic             tap_sel,
    output logic             din
);

    localparam int          MSB = WIDTH - 1;
    localparam logic [MSB:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [MSB:0] ALT_MASK = (ONE << MSB) | (ONE << (WIDTH - 3));

    logic [MSB:0] max_mask;

    generate
        if (WIDTH == 8) begin : g_w8
            assign max_mask = (ONE << 7) | (ONE << 6) | (ONE << 5) | ONE;
        end else if (WIDTH == 32) begin : g_w32
            assign max_mask = (ONE << 31) | (ONE << 30) | (ONE << 29) | (ONE << 9);
        end else begin : g_wn
            assign max_mask = (ONE << MSB) | (ONE << (WIDTH - 2));
        end
    endgenerate

    logic lfsr_bit;
    assign lfsr_bit = ^(state & (tap_sel ? ALT_MASK : max_mask));

    always_comb begin
        unique case (src)
            SRC_SERIAL: din = ser_in;
            SRC_RING:   din = state[MSB];
            SRC_TWIST:  din = ~state[MSB];
            SRC_LFSR:   din = lfsr_bit;
            default:    din = 1'b0;
        endcase
    end

    // R8: an all-zero state can only produce a zero feedback bit
    always_comb begin
        if (src == SRC_LFSR && state == '0) begin
            a_zero_feedback_r8: assert (din == 1'b0);
        end
    end

endmodule

// File: rtl/fbsr_chain.sv
module fbsr_chain #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             din,
    output logic [WIDTH-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (advance) begin
            state <= {state[WIDTH-2:0], din};
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> state == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> state == $past(state));

endmodule

// File: rtl/fbsr_top.sv
module fbsr_top
    import fbsr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic             sel_run,
    input  logic [1:0]       fb_mode,
    input  logic             tap_sel,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    src_e src;
    logic din;

    fbsr_src_sel u_sel (
        .shift_en (shift_en),
        .sel_run  (sel_run),
        .mode     (fb_mode_e'(fb_mode)),
        .src      (src)
    );

    fbsr_feedback #(.WIDTH(WIDTH)) u_fb (
        .state   (q),
        .src     (src),
        .ser_in  (ser_in),
        .tap_sel (tap_sel),
        .din     (din)
    );

    fbsr_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .advance (src != SRC_HOLD),
        .din     (din),
        .state   (q)
    );

    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> q[MSB:1] == $past(q[MSB-1:0]));

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !sel_run) |=> q[0] == $past(ser_in));

    p_ring_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && sel_run && fb_mode == 2'b00) |=> q[0] == $past(q[MSB]));

    p_twist_r6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && sel_run && fb_mode == 2'b01) |=> q[0] != $past(q[MSB]));

    p_zero_lock_r8: assert property (@(posedge clk) disable iff (rst)
        (shift_en && sel_run && fb_mode[1] && q == '0) |=> q == '0);

endmodule

// File: tb/test_fbsr_top.sv
`timescale 1ns/1ps
module test_fbsr_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       sel_run = 1'b0;
    logic [1:0] fb_mode = 2'b00;
    logic       tap_sel = 1'b0;
    logic [3:0] q;
    logic [7:0] q8;

    fbsr_top #(.WIDTH(4)) i_fbsr_top (
        .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
        .sel_run(sel_run), .fb_mode(fb_mode), .tap_sel(tap_sel), .q(q)
    );

    fbsr_top #(.WIDTH(8)) i_fbsr_top_w8 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
        .sel_run(sel_run), .fb_mode(fb_mode), .tap_sel(tap_sel), .q(q8)
    );

    typedef struct {
        logic [3:0] val;
        int         tag;
    } exp_t;

    exp_t       sb[$];
    exp_t       cur;
    logic [3:0] model = 4'b0000;
    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;

    // Expected next state written from the requirement equations (R1..R9, width 4)
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic r, e, sd,
                                            input logic run, input logic [1:0] m, input logic t);
        logic b;
        if (r) return 4'b0000;
        if (!e) return s;
        if (!run)           b = sd;
        else if (m == 2'b00) b = s[3];
        else if (m == 2'b01) b = ~s[3];
        else if (t)          b = s[3] ^ s[1];
        else                 b = s[3] ^ s[2];
        return {s[2:0], b};
    endfunction

    // Driver: called at a falling edge, applies inputs, queues the value expected after the next rising edge
    task automatic drive(input logic r, e, sd, run, input logic [1:0] m, input logic t, input int tag);
        rst = r; shift_en = e; ser_in = sd; sel_run = run; fb_mode = m; tap_sel = t;
        model = ref_next(model, r, e, sd, run, m, t);
        sb.push_back('{val: model, tag: tag});
        @(negedge clk);
    endtask

    // Monitor: compares each queued expectation just after the edge that produces it
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            tests++;
            if (q !== cur.val) begin
                fails++;
                $display("FAIL R%0d: q actual %b expected %b", cur.tag, q, cur.val);
            end
        end
    end

    task automatic check_count(input int actual, input int expected, input string req);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: period actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic measure(input logic [1:0] m, input logic t, input int expected,
                           input bit wide, input string req, input int tag);
        logic [7:0] seed;
        int n;
        seed = wide ? q8 : {4'b0000, q};
        n = 0;
        do begin
            drive(1'b0, 1'b1, 1'b0, 1'b1, m, t, tag);
            n++;
        end while (((wide ? q8 : {4'b0000, q}) !== seed) && n < 300);
        check_count(n, expected, req);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset clears, also with enable and serial data high
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1);
        // R2 / R3: load 1100 serially with a feedback code present (ignored in load mode)
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 3);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1, 3);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 2);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2);
        // R4: enable low holds regardless of the other inputs
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 4);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 4);
        tests++;
        if (q !== 4'b1100) begin
            fails++;
            $display("FAIL R4: held q actual %b expected %b", q, 4'b1100);
        end
        // R5: ring period 4
        measure(2'b00, 1'b0, 4, 1'b0, "R5", 5);
        // R6: twisted ring from zero, period 8
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1);
        measure(2'b01, 1'b0, 8, 1'b0, "R6", 6);
        // R7: maximal taps from 1111, period 15 with both 1x codes
        for (int i = 0; i < 4; i++) drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 3);
        measure(2'b10, 1'b0, 15, 1'b0, "R7", 7);
        measure(2'b11, 1'b0, 15, 1'b0, "R7", 7);
        // R8: all-zero locks in linear-feedback mode
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1);
        measure(2'b10, 1'b0, 1, 1'b0, "R8", 8);
        measure(2'b11, 1'b1, 1, 1'b0, "R8", 8);
        // R9: alternative taps from 0001, period 6
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 3);
        measure(2'b10, 1'b1, 6, 1'b0, "R9", 9);
        // R10: 8-bit instance with maximal taps from 00000001, period 255
        drive(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 3);
        tests++;
        if (q8 !== 8'h01) begin
            fails++;
            $display("FAIL R10: seed q8 actual %h expected %h", q8, 8'h01);
        end
        measure(2'b10, 1'b0, 255, 1'b1, "R10", 10);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule